// File: doc/BRIEF.md
# Voltage and Frequency Transition Sequencer

This block moves a design from one performance point to another. It drives two codes. One is a frequency code for a programmable clock generator: code k selects 200 + 33·k MHz, and codes 0 to 15 are valid. The other is a 5-bit supply code for a regulator with 32 levels, from code 0 (1.1 V) to code 31 (1.6 V). Software asks for a frequency code. The block looks up the lowest permitted supply code for that frequency in a small writable table. It then applies the two changes in an order that never clocks the logic faster than its supply allows.

A speed-up raises the supply first, waits for the regulator's settle acknowledge, and only then changes the clock. A slow-down lowers the clock first, waits for the generator's lock acknowledge, and only then lowers the supply. A hold-supply mode bit changes only the frequency. Each wait step has a cycle limit. If a step runs past its limit, the block undoes only the code that step changed, which leaves a safe point, and it raises a sticky error flag.

After reset the block drives frequency code 0 and the table's reset supply for that code. It then waits for a lock acknowledge before it reports ready.

Top module: `dvfs_seq_ctrl`

## Requirements
- R1: While reset is held, freq_code is 0 and volt_code is 1, which is the reset table entry for code 0. After reset, ready stays low and busy stays low until the first lock_ack pulse. ready rises on the cycle after that pulse.
- R2: A request whose code is above 15 is refused. reject pulses high for one cycle on the cycle after the request, ready stays high, and neither code changes. freq_code never exceeds 15.
- R3: When hold_volt is low, the target supply code is the table entry for the requested frequency code. The reset content of entry k is min(2k+1, 31).
- R4: When the target frequency code is greater than or equal to the current one, a supply change (if any) is applied first. The frequency code changes only on the cycle after a settle_ack pulse. freq_code and volt_code never change in the same cycle.
- R5: When the target frequency code is lower than the current one, the frequency code is applied first. A supply change (if any) is applied only on the cycle after a lock_ack pulse.
- R6: When hold_volt is high, the supply code stays at its current value and only the frequency code moves.
- R7: A table write (tbl_we, tbl_addr, tbl_wdata) takes effect only while ready is high and tbl_addr is 15 or below. Other writes are dropped.
- R8: A valid request that equals the current point changes neither code. It pulses done on the next cycle, and busy stays low.
- R9: busy is high from the cycle after a request is accepted until the final acknowledge is taken. busy and ready are never both high. Requests made while busy are ignored. done pulses in the cycle in which ready returns after a successful change.
- R10: Suppose a wait step gets no matching acknowledge at any of the tmo_limit clock edges after the step begins. On the last of those edges the step ends: the code that step changed goes back to its value before the step, err is set, and the block returns to ready without pulsing done.
- R11: err stays set until err_clr is pulsed. err_clr clears it on the next cycle.
- R12: An acknowledge that does not match the current wait step (lock_ack while waiting for supply, or either acknowledge while idle) has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken only while ready |
| req_fcode | input | 5 | Requested frequency code |
| hold_volt | input | 1 | Keep the supply code, change only the frequency |
| tbl_we | input | 1 | Table write enable |
| tbl_addr | input | 5 | Table entry (frequency code) to write |
| tbl_wdata | input | 5 | Minimum supply code to store |
| tmo_limit | input | 16 | Cycle limit for each wait step |
| settle_ack | input | 1 | One-cycle pulse: supply has settled |
| lock_ack | input | 1 | One-cycle pulse: clock generator has locked |
| err_clr | input | 1 | Write-one-to-clear for err |
| freq_code | output | 5 | Frequency code to the clock generator |
| volt_code | output | 5 | Supply code to the regulator |
| ready | output | 1 | Idle and able to take a request |
| busy | output | 1 | A transition is in progress |
| done | output | 1 | One-cycle pulse when a request completes |
| reject | output | 1 | One-cycle pulse when a request is refused |
| err | output | 1 | Sticky wait-step timeout flag |

## Verification
The hardest cases to reach are the timeouts. Each one has to hit a chosen step: the supply step of a speed-up, the clock step of a speed-up, or the supply step of a slow-down. The one-cycle edge of the limit must also be observed. The bench models the regulator and the clock generator as a responder that acknowledges each code change after a fixed delay. The stimulus can mute either acknowledge for one request, which forces the block to wait out the chosen step. During that wait the bench injects an acknowledge that does not match the step, samples err on the cycles just before and just after the limit, and confirms that only the last-changed code returns.

// File: rtl/dvfs_pkg.sv
package dvfs_pkg;

    localparam int FCODE_W       = 5;
    localparam int VCODE_W       = 5;
    localparam int FREQ_BASE_MHZ = 200;
    localparam int FREQ_STEP_MHZ = 33;
    localparam int FREQ_CEIL_MHZ = 700;
    localparam int FCODE_MAX     = (FREQ_CEIL_MHZ - FREQ_BASE_MHZ) / FREQ_STEP_MHZ;
    localparam int NUM_PTS       = FCODE_MAX + 1;
    localparam int VCODE_TOP     = (1 << VCODE_W) - 1;

    typedef enum logic [2:0] {
        ST_BOOT,
        ST_IDLE,
        ST_RAISE_V,
        ST_RAISE_F,
        ST_LOWER_F,
        ST_LOWER_V
    } seq_state_e;

    typedef struct packed {
        logic [FCODE_W-1:0] fc;
        logic [VCODE_W-1:0] vc;
    } op_point_t;

    function automatic logic [VCODE_W-1:0] vmin_default(input int k);
        int v;
        v = 2 * k + 1;
        if (v > VCODE_TOP) v = VCODE_TOP;
        return VCODE_W'(v);
    endfunction

    function automatic logic fcode_legal(input logic [FCODE_W-1:0] c);
        return c <= FCODE_W'(FCODE_MAX);
    endfunction

endpackage

// File: rtl/dvfs_vmin_table.sv
module dvfs_vmin_table #(
    parameter int DEPTH = dvfs_pkg::NUM_PTS,
    parameter int VW    = dvfs_pkg::VCODE_W,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [VW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [VW-1:0] rdata
);
    logic [DEPTH-1:0][VW-1:0] ent;

    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        always_ff @(posedge clk) begin
            if (rst)
                ent[i] <= VW'(dvfs_pkg::vmin_default(i));
            else if (we && waddr == AW'(i))
                ent[i] <= wdata;
        end
    end

    assign rdata = ent[raddr];
endmodule

// File: rtl/dvfs_wait_timer.sv
module dvfs_wait_timer #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          restart,
    input  logic [TW-1:0] limit,
    output logic          expire
);
    logic [TW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || restart)
            cnt <= '0;
        else if (cnt != {TW{1'b1}})
            cnt <= cnt + 1'b1;
    end

    // Expires on the limit-th edge after the restart edge.
    assign expire = ({1'b0, cnt} + 1'b1) >= {1'b0, limit};
endmodule

// File: rtl/dvfs_seq_fsm.sv
module dvfs_seq_fsm
    import dvfs_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic [FCODE_W-1:0] req_fc,
    input  logic               hold_volt,
    input  logic [VCODE_W-1:0] tbl_vmin,
    input  logic               settle_ack,
    input  logic               lock_ack,
    input  logic               tmo_expire,
    input  logic               err_clr,
    output op_point_t          cur_pt,
    output seq_state_e         state_q,
    output logic               tmr_restart,
    output logic               done,
    output logic               reject,
    output logic               err
);
    seq_state_e state_d;
    op_point_t  cur_d, tgt_q, tgt_d, prev_q, prev_d;
    logic       done_d, reject_d, err_set;
    logic [VCODE_W-1:0] want_v;

    assign want_v = hold_volt ? cur_pt.vc : tbl_vmin;

    always_comb begin
        state_d  = state_q;
        cur_d    = cur_pt;
        tgt_d    = tgt_q;
        prev_d   = prev_q;
        done_d   = 1'b0;
        reject_d = 1'b0;
        err_set  = 1'b0;
        unique case (state_q)
            ST_BOOT: begin
                if (lock_ack) state_d = ST_IDLE;
            end
            ST_IDLE: begin
                if (req_valid) begin
                    if (!fcode_legal(req_fc)) begin
                        reject_d = 1'b1;
                    end else begin
                        tgt_d  = '{fc: req_fc, vc: want_v};
                        prev_d = cur_pt;
                        if (req_fc == cur_pt.fc && want_v == cur_pt.vc) begin
                            done_d = 1'b1;
                        end else if (req_fc >= cur_pt.fc) begin
                            if (want_v != cur_pt.vc) begin
                                cur_d.vc = want_v;
                                state_d  = ST_RAISE_V;
                            end else begin
                                cur_d.fc = req_fc;
                                state_d  = ST_RAISE_F;
                            end
                        end else begin
                            cur_d.fc = req_fc;
                            state_d  = ST_LOWER_F;
                        end
                    end
                end
            end
            ST_RAISE_V: begin
                if (settle_ack) begin
                    if (tgt_q.fc != cur_pt.fc) begin
                        cur_d.fc = tgt_q.fc;
                        state_d  = ST_RAISE_F;
                    end else begin
                        done_d  = 1'b1;
                        state_d = ST_IDLE;
                    end
                end else if (tmo_expire) begin
                    cur_d.vc = prev_q.vc;
                    err_set  = 1'b1;
                    state_d  = ST_IDLE;
                end
            end
            ST_RAISE_F: begin
                if (lock_ack) begin
                    done_d  = 1'b1;
                    state_d = ST_IDLE;
                end else if (tmo_expire) begin
                    cur_d.fc = prev_q.fc;
                    err_set  = 1'b1;
                    state_d  = ST_IDLE;
                end
            end
            ST_LOWER_F: begin
                if (lock_ack) begin
                    if (tgt_q.vc != cur_pt.vc) begin
                        cur_d.vc = tgt_q.vc;
                        state_d  = ST_LOWER_V;
                    end else begin
                        done_d  = 1'b1;
                        state_d = ST_IDLE;
                    end
                end else if (tmo_expire) begin
                    cur_d.fc = prev_q.fc;
                    err_set  = 1'b1;
                    state_d  = ST_IDLE;
                end
            end
            ST_LOWER_V: begin
                if (settle_ack) begin
                    done_d  = 1'b1;
                    state_d = ST_IDLE;
                end else if (tmo_expire) begin
                    cur_d.vc = prev_q.vc;
                    err_set  = 1'b1;
                    state_d  = ST_IDLE;
                end
            end
            default: state_d = ST_BOOT;
        endcase
    end

    assign tmr_restart = (state_d != state_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_BOOT;
            cur_pt  <= '{fc: '0, vc: vmin_default(0)};
            tgt_q   <= '{fc: '0, vc: vmin_default(0)};
            prev_q  <= '{fc: '0, vc: vmin_default(0)};
            done    <= 1'b0;
            reject  <= 1'b0;
            err     <= 1'b0;
        end else begin
            state_q <= state_d;
            cur_pt  <= cur_d;
            tgt_q   <= tgt_d;
            prev_q  <= prev_d;
            done    <= done_d;
            reject  <= reject_d;
            err     <= (err && !err_clr) || err_set;
        end
    end
endmodule

// File: rtl/dvfs_seq_ctrl.sv
module dvfs_seq_ctrl #(
    parameter int TMO_W = 16,
    localparam int FW   = dvfs_pkg::FCODE_W,
    localparam int VW   = dvfs_pkg::VCODE_W,
    localparam int AW   = $clog2(dvfs_pkg::NUM_PTS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic [FW-1:0]    req_fcode,
    input  logic             hold_volt,
    input  logic             tbl_we,
    input  logic [FW-1:0]    tbl_addr,
    input  logic [VW-1:0]    tbl_wdata,
    input  logic [TMO_W-1:0] tmo_limit,
    input  logic             settle_ack,
    input  logic             lock_ack,
    input  logic             err_clr,
    output logic [FW-1:0]    freq_code,
    output logic [VW-1:0]    volt_code,
    output logic             ready,
    output logic             busy,
    output logic             done,
    output logic             reject,
    output logic             err
);
    import dvfs_pkg::*;

    op_point_t  cur_pt;
    seq_state_e state_q;
    logic       tmr_restart, tmo_expire, tbl_wr_ok;
    logic [VW-1:0] tbl_vmin;

    assign ready     = (state_q == ST_IDLE);
    assign busy      = (state_q == ST_RAISE_V) || (state_q == ST_RAISE_F) ||
                       (state_q == ST_LOWER_F) || (state_q == ST_LOWER_V);
    assign tbl_wr_ok = tbl_we && ready && fcode_legal(tbl_addr);

    dvfs_vmin_table #(.DEPTH(NUM_PTS), .VW(VW)) u_table (
        .clk   (clk),
        .rst   (rst),
        .we    (tbl_wr_ok),
        .waddr (tbl_addr[AW-1:0]),
        .wdata (tbl_wdata),
        .raddr (req_fcode[AW-1:0]),
        .rdata (tbl_vmin)
    );

    dvfs_wait_timer #(.TW(TMO_W)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .restart (tmr_restart),
        .limit   (tmo_limit),
        .expire  (tmo_expire)
    );

    dvfs_seq_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .req_valid   (req_valid),
        .req_fc      (req_fcode),
        .hold_volt   (hold_volt),
        .tbl_vmin    (tbl_vmin),
        .settle_ack  (settle_ack),
        .lock_ack    (lock_ack),
        .tmo_expire  (tmo_expire),
        .err_clr     (err_clr),
        .cur_pt      (cur_pt),
        .state_q     (state_q),
        .tmr_restart (tmr_restart),
        .done        (done),
        .reject      (reject),
        .err         (err)
    );

    assign freq_code = cur_pt.fc;
    assign volt_code = cur_pt.vc;
endmodule

// File: rtl/dvfs_seq_chk.sv
module dvfs_seq_chk #(
    parameter int FW = dvfs_pkg::FCODE_W,
    parameter int VW = dvfs_pkg::VCODE_W
) (
    input logic          clk,
    input logic          rst,
    input logic [FW-1:0] freq_code,
    input logic [VW-1:0] volt_code,
    input logic          ready,
    input logic          busy,
    input logic          done,
    input logic          reject,
    input logic          err,
    input logic          err_clr
);
    AST_FREQ_LEGAL: assert property (@(posedge clk) disable iff (rst)
        freq_code <= FW'(dvfs_pkg::FCODE_MAX)); // R2

    AST_REJECT_HOLDS: assert property (@(posedge clk) disable iff (rst)
        reject |-> ($stable(freq_code) && $stable(volt_code) && ready)); // R2

    AST_ONE_CODE_STEP: assert property (@(posedge clk) disable iff (rst)
        !$stable(freq_code) |-> $stable(volt_code)); // R4

    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (rst)
        !(busy && ready)); // R9

    AST_DONE_IN_IDLE: assert property (@(posedge clk) disable iff (rst)
        done |-> (ready && !reject)); // R8

    AST_ERR_RETURNS_IDLE: assert property (@(posedge clk) disable iff (rst)
        $rose(err) |-> (ready && !done)); // R10

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        (err && !err_clr) |=> err); // R11
endmodule

bind dvfs_seq_ctrl dvfs_seq_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .freq_code (freq_code),
    .volt_code (volt_code),
    .ready     (ready),
    .busy      (busy),
    .done      (done),
    .reject    (reject),
    .err       (err),
    .err_clr   (err_clr)
);

// File: tb/tb_dvfs_seq_ctrl.sv
`timescale 1ns/1ps
module tb_dvfs_seq_ctrl;
    localparam int TMO = 20;
    localparam int LAT = 3;

    logic       clk = 1'b0;
    logic       rst;
    logic       req_valid, hold_volt, tbl_we, settle_ack, lock_ack, err_clr;
    logic [4:0] req_fcode, tbl_addr, tbl_wdata;
    logic [15:0] tmo_limit;
    logic [4:0] freq_code, volt_code;
    logic       ready, busy, done, reject, err;

    always #4 clk = ~clk;

    dvfs_seq_ctrl dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_fcode(req_fcode),
        .hold_volt(hold_volt), .tbl_we(tbl_we), .tbl_addr(tbl_addr),
        .tbl_wdata(tbl_wdata), .tmo_limit(tmo_limit), .settle_ack(settle_ack),
        .lock_ack(lock_ack), .err_clr(err_clr), .freq_code(freq_code),
        .volt_code(volt_code), .ready(ready), .busy(busy), .done(done),
        .reject(reject), .err(err)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    typedef struct { int f; int v; string tag; } pt_t;
    pt_t exp_q[$];

    int model_tbl[16];
    int cur_f, cur_v;
    bit exp_err;
    bit mute_v = 0, mute_l = 0;
    int kick_req = 0;

    task automatic chk(input bit ok, input string rq, input string what,
                       input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, expv);
        end
    endtask

    task automatic push(input int f, input int v, input string tag);
        pt_t p;
        p.f = f; p.v = v; p.tag = tag;
        exp_q.push_back(p);
    endtask

    // Model of regulator and clock generator: acknowledge each code change.
    initial begin
        int lv, lf, vcnt, lcnt, kick_seen;
        vcnt = 0; lcnt = 0; kick_seen = 0; lv = 0; lf = 0;
        settle_ack = 0; lock_ack = 0;
        forever begin
            @(negedge clk);
            settle_ack = 0;
            lock_ack = 0;
            if (kick_req != kick_seen) begin
                kick_seen = kick_req;
                lock_ack = 1;
            end
            if (vcnt > 0) begin vcnt--; if (vcnt == 0) settle_ack = 1; end
            if (lcnt > 0) begin lcnt--; if (lcnt == 0) lock_ack = 1; end
            if (!rst) begin
                if (int'(volt_code) != lv && !mute_v) vcnt = LAT;
                if (int'(freq_code) != lf && !mute_l) lcnt = LAT;
            end
            lv = volt_code;
            lf = freq_code;
        end
    end

    // Scoreboard monitor: each change of the code pair must match the next expected point.
    initial begin
        int mf, mv;
        mf = 0; mv = 1;
        forever begin
            @(negedge clk);
            if (rst) begin
                mf = freq_code; mv = volt_code;
            end else if (int'(freq_code) != mf || int'(volt_code) != mv) begin
                if (exp_q.size() == 0) begin
                    chk(0, "R4", "unexpected code change freq", freq_code, mf);
                end else begin
                    pt_t p;
                    p = exp_q.pop_front();
                    chk(int'(freq_code) == p.f, p.tag, "step freq_code", freq_code, p.f);
                    chk(int'(volt_code) == p.v, p.tag, "step volt_code", volt_code, p.v);
                end
                mf = freq_code; mv = volt_code;
            end
        end
    end

    // Driver: predicts the code sequence, issues the request, waits for ready.
    task automatic do_req(input int fc, input bit fx, input string tag,
                          input bit poke, input bit probe);
        int tv, n;
        bit refused, equal, fail_path;
        refused = (fc > 15);
        tv = refused ? cur_v : (fx ? cur_v : model_tbl[fc]);
        equal = !refused && fc == cur_f && tv == cur_v;
        fail_path = 0;
        if (!refused && !equal) begin
            if (fc >= cur_f) begin
                if (tv != cur_v) begin
                    push(cur_f, tv, tag);
                    if (mute_v) begin push(cur_f, cur_v, "R10"); fail_path = 1; end
                end
                if (!fail_path && fc != cur_f) begin
                    push(fc, tv, tag);
                    if (mute_l) begin push(cur_f, tv, "R10"); fail_path = 1; cur_v = tv; end
                end
                if (!fail_path) begin cur_f = fc; cur_v = tv; end
            end else begin
                push(fc, cur_v, tag);
                if (mute_l) begin
                    push(cur_f, cur_v, "R10"); fail_path = 1;
                end else if (tv != cur_v) begin
                    push(fc, tv, tag);
                    if (mute_v) begin push(fc, cur_v, "R10"); fail_path = 1; cur_f = fc; end
                end
                if (!fail_path) begin cur_f = fc; cur_v = tv; end
            end
        end
        if (fail_path) exp_err = 1;

        @(negedge clk);
        req_valid = 1; req_fcode = 5'(fc); hold_volt = fx;
        @(negedge clk);
        req_valid = 0;
        if (refused) begin
            chk(reject == 1, "R2", "reject pulse", reject, 1);
            chk(ready == 1, "R2", "ready after refusal", ready, 1);
        end else if (equal) begin
            chk(done == 1, "R8", "done for same point", done, 1);
            chk(busy == 0, "R8", "busy for same point", busy, 0);
        end else begin
            chk(busy == 1 && ready == 0, "R9", "busy after accept", busy, 1);
        end
        if (poke) begin
            req_valid = 1; req_fcode = 5'd1;
            tbl_we = 1; tbl_addr = 5'd1; tbl_wdata = 5'd0;
            @(negedge clk);
            req_valid = 0; tbl_we = 0;
        end
        if (probe) begin
            for (int i = 0; i < TMO - 1; i++) begin
                if (i == 4) kick_req++;
                @(negedge clk);
            end
            chk(err == 0, "R10", "err before limit edge", err, 0);
            chk(busy == 1, "R12", "stray lock_ack ignored, still busy", busy, 1);
            @(negedge clk);
            chk(err == 1, "R10", "err on limit edge", err, 1);
            chk(ready == 1, "R10", "ready on limit edge", ready, 1);
        end
        n = 0;
        while (!ready && n < 400) begin @(negedge clk); n++; end
        if (!refused && !equal && !probe)
            chk(done == !fail_path, fail_path ? "R10" : "R9", "done at completion",
                done, !fail_path);
        chk(int'(freq_code) == cur_f, tag, "final freq_code", freq_code, cur_f);
        chk(int'(volt_code) == cur_v, tag, "final volt_code", volt_code, cur_v);
        chk(err == exp_err, "R11", "err level", err, exp_err);
        repeat (LAT + 3) @(negedge clk);
        chk(exp_q.size() == 0, tag, "pending expected steps", exp_q.size(), 0);
        exp_q.delete();
    endtask

    task automatic tbl_write(input int a, input int d);
        @(negedge clk);
        tbl_we = 1; tbl_addr = 5'(a); tbl_wdata = 5'(d);
        @(negedge clk);
        tbl_we = 0;
        if (a <= 15) model_tbl[a] = d;
    endtask

    initial begin
        #(8ns * 200000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < 16; k++) model_tbl[k] = (2 * k + 1 > 31) ? 31 : 2 * k + 1;
        cur_f = 0; cur_v = 1; exp_err = 0;
        rst = 1; req_valid = 0; req_fcode = 0; hold_volt = 0; tbl_we = 0;
        tbl_addr = 0; tbl_wdata = 0; err_clr = 0; tmo_limit = 16'(TMO);
        repeat (3) @(negedge clk);
        chk(freq_code == 0, "R1", "reset freq_code", freq_code, 0);
        chk(volt_code == 1, "R1", "reset volt_code", volt_code, 1);
        rst = 0;
        repeat (5) @(negedge clk);
        chk(ready == 0 && busy == 0, "R1", "ready before lock", ready, 0);
        kick_req++;
        @(negedge clk);
        @(negedge clk);
        chk(ready == 1, "R1", "ready after lock", ready, 1);

        do_req(5, 0, "R4", 1, 0);        // speed-up, with ignored request and write while busy
        do_req(2, 0, "R5", 0, 0);        // slow-down
        do_req(9, 1, "R6", 0, 0);        // hold supply, up
        do_req(3, 1, "R6", 0, 0);        // hold supply, down
        do_req(3, 1, "R8", 0, 0);        // same point
        do_req(3, 0, "R3", 0, 0);        // supply from table only
        tbl_write(12, 30);
        do_req(12, 0, "R7", 0, 0);
        tbl_write(20, 0);                // out of range, dropped (would alias entry 4)
        do_req(4, 0, "R7", 0, 0);
        do_req(1, 0, "R7", 0, 0);        // entry 1 untouched by busy write
        do_req(16, 0, "R2", 0, 0);
        do_req(31, 0, "R2", 0, 0);

        mute_v = 1;
        do_req(10, 0, "R10", 0, 1);      // supply step of speed-up times out
        mute_v = 0;
        repeat (10) @(negedge clk);
        chk(err == 1, "R11", "err sticky", err, 1);
        err_clr = 1; @(negedge clk); err_clr = 0;
        chk(err == 0, "R11", "err cleared", err, 0);
        exp_err = 0;

        mute_l = 1;
        do_req(10, 0, "R10", 0, 0);      // clock step of speed-up times out
        mute_l = 0;
        mute_v = 1;
        do_req(0, 0, "R10", 0, 0);       // supply step of slow-down times out
        mute_v = 0;
        err_clr = 1; @(negedge clk); err_clr = 0;
        exp_err = 0;
        do_req(6, 0, "R4", 0, 0);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule